// File: doc/BRIEF.md
# Debug Cross-Trigger Router

This block connects up to eight local debug event sources and eight local debug event sinks to a small set of broadcast channels that a shared channel matrix carries between blocks. Each local source has a channel mask that decides which channels it raises. Each local sink has a channel mask that decides which channels it responds to. A separate gate decides which locally raised channels are driven out toward the matrix. Channel events that arrive from the matrix take part in local routing, but they are never sent back out, so the block cannot form a loop through the matrix.

Software configures the block through a plain memory-mapped port with 12-bit byte addresses and 32-bit data. A write is taken in the cycle that `bus_we` is high, and a read returns data combinationally for the address presented. The port has no valid/ready handshake, because it never applies back-pressure: every cycle can carry a write. Configuration writes stay blocked until a 32-bit key has been written. A global enable turns all routing on or off. Trigger and channel outputs are registered.

Top module: `xtrig_hub`

## Requirements
- R1: After reset, the block is locked and disabled. All input masks, output masks and the gate read as zero, and `trig_out` and `chan_out` are low.
- R2: While the block is locked, writes to any address other than 0xFB0 leave every register unchanged. The status register at 0xFB4 reads 0x2 while locked and 0x0 while unlocked.
- R3: Writing 0xC5ACCE55 to 0xFB0 unlocks the block. Writing any other value to 0xFB0 locks it again.
- R4: Bit 0 of the control register at 0x000 enables routing. While that bit is 0, `trig_out` and `chan_out` are low, and all mask and gate registers keep their values.
- R5: The input mask for trigger input n is at 0x020+4n, for n from 0 to 7. When bit k is set, a high on `trig_in[n]` makes channel k active.
- R6: The output mask for trigger output n is at 0x0A0+4n. When bit k is set and channel k is active, `trig_out[n]` goes high. When the mask is zero, the output stays low.
- R7: A high on `chan_in[k]` makes channel k active for trigger outputs, but it never appears on `chan_out`.
- R8: The gate register at 0x140 holds one bit per channel. `chan_out[k]` goes high only when channel k is raised by a local trigger input and gate bit k is set.
- R9: A channel is the OR of every input mapped to it. An output is the OR of every active channel in its mask.
- R10: Outputs follow their inputs one clock later. A single-cycle input pulse gives a single-cycle output pulse, and a held level gives a held output.
- R11: Every register reads back its stored value. Mask and gate registers store only bits [3:0], and all other bits read as zero. Addresses that map to no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_in | input | 8 | Local trigger events, as pulses or levels |
| trig_out | output | 8 | Registered local trigger outputs |
| chan_in | input | 4 | Channel events arriving from the matrix |
| chan_out | output | 4 | Gated, registered channel events toward the matrix |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The hardest case to reach from the ports is a held level and a single-cycle pulse from two different inputs landing on one channel while a matrix channel drives an overlapping output. In that case every output has to combine several contributors in exactly the right cycle. The stimulus first builds a mapping in which two inputs share channel 0, one input fans out to two channels, and one output listens to all four channels. It then drives pulse and level trains, with and without inbound channel bits, into a per-cycle scoreboard. Writes that the lock rejects can only be seen through readback, so each rejected write is followed by a read of the register it targeted.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int unsigned XT_OFS_CTRL   = 32'h000;
  localparam int unsigned XT_OFS_INMAP  = 32'h020;
  localparam int unsigned XT_OFS_OUTMAP = 32'h0A0;
  localparam int unsigned XT_OFS_GATE   = 32'h140;
  localparam int unsigned XT_OFS_KEY    = 32'hFB0;
  localparam int unsigned XT_OFS_LKST   = 32'hFB4;
  localparam logic [31:0] XT_KEY        = 32'hC5AC_CE55;
  localparam int unsigned XT_LKST_BIT   = 1;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_we,
  input  logic [AW-1:0]                  bus_addr,
  input  logic [DW-1:0]                  bus_wdata,
  output logic [DW-1:0]                  bus_rdata,
  output logic                           en_o,
  output logic [N_TRIG-1:0][N_CHAN-1:0]  in_map_o,
  output logic [N_TRIG-1:0][N_CHAN-1:0]  out_map_o,
  output logic [N_CHAN-1:0]              gate_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(XT_OFS_CTRL);
  localparam logic [AW-1:0] A_GATE = AW'(XT_OFS_GATE);
  localparam logic [AW-1:0] A_KEY  = AW'(XT_OFS_KEY);
  localparam logic [AW-1:0] A_LKST = AW'(XT_OFS_LKST);
  localparam logic [DW-1:0] KEYVAL = DW'(XT_KEY);

  logic                          locked_q;
  logic                          en_q;
  logic [N_CHAN-1:0]             gate_q;
  logic [N_TRIG-1:0][N_CHAN-1:0] in_map_q;
  logic [N_TRIG-1:0][N_CHAN-1:0] out_map_q;
  logic                          wr_open;
  logic                          key_hit;

  assign wr_open = bus_we && !locked_q;
  assign key_hit = bus_we && (bus_addr == A_KEY);

  // lock: any write to the key register sets or clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked_q <= 1'b1;
    else if (key_hit) locked_q <= (bus_wdata != KEYVAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      gate_q <= '0;
    end else if (wr_open) begin
      if (bus_addr == A_CTRL) en_q   <= bus_wdata[0];
      if (bus_addr == A_GATE) gate_q <= bus_wdata[N_CHAN-1:0];
    end
  end

  for (genvar g = 0; g < N_TRIG; g++) begin : g_map
    localparam logic [AW-1:0] A_IN  = AW'(XT_OFS_INMAP + 4*g);
    localparam logic [AW-1:0] A_OUT = AW'(XT_OFS_OUTMAP + 4*g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_map_q[g]  <= '0;
        out_map_q[g] <= '0;
      end else if (wr_open) begin
        if (bus_addr == A_IN)  in_map_q[g]  <= bus_wdata[N_CHAN-1:0];
        if (bus_addr == A_OUT) out_map_q[g] <= bus_wdata[N_CHAN-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata[0] = en_q;
    if (bus_addr == A_GATE) bus_rdata[N_CHAN-1:0] = gate_q;
    if (bus_addr == A_LKST) bus_rdata[XT_LKST_BIT] = locked_q;
    for (int n = 0; n < N_TRIG; n++) begin
      if (bus_addr == AW'(XT_OFS_INMAP + 4*n))  bus_rdata[N_CHAN-1:0] = in_map_q[n];
      if (bus_addr == AW'(XT_OFS_OUTMAP + 4*n)) bus_rdata[N_CHAN-1:0] = out_map_q[n];
    end
  end

  assign en_o      = en_q;
  assign in_map_o  = in_map_q;
  assign out_map_o = out_map_q;
  assign gate_o    = gate_q;

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_we && bus_addr != A_KEY) |=>
      ($stable(en_q) && $stable(gate_q) && $stable(in_map_q) && $stable(out_map_q)));

  assert_key_unlocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_KEY && bus_wdata == KEYVAL) |=> !locked_q);

  assert_bad_key_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_KEY && bus_wdata != KEYVAL) |=> locked_q);
endmodule

// File: rtl/xtrig_route.sv
module xtrig_route #(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic [N_TRIG-1:0]             trig_in_i,
  input  logic [N_CHAN-1:0]             chan_in_i,
  input  logic [N_TRIG-1:0][N_CHAN-1:0] in_map_i,
  input  logic [N_TRIG-1:0][N_CHAN-1:0] out_map_i,
  input  logic [N_CHAN-1:0]             gate_i,
  output logic [N_TRIG-1:0]             trig_out_o,
  output logic [N_CHAN-1:0]             chan_out_o
);
  logic [N_CHAN-1:0] local_ch;
  logic [N_CHAN-1:0] act_ch;
  logic [N_TRIG-1:0] trig_nx;
  logic [N_TRIG-1:0] trig_q;
  logic [N_CHAN-1:0] chan_q;

  // fan-in: each channel is the OR of all inputs mapped onto it
  always_comb begin
    local_ch = '0;
    for (int n = 0; n < N_TRIG; n++) begin
      local_ch = local_ch | ({N_CHAN{trig_in_i[n]}} & in_map_i[n]);
    end
  end

  assign act_ch = local_ch | chan_in_i;

  // fan-out: one OR-reduce per trigger output
  for (genvar g = 0; g < N_TRIG; g++) begin : g_out
    assign trig_nx[g] = en_i & (|(out_map_i[g] & act_ch));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      chan_q <= '0;
    end else begin
      trig_q <= trig_nx;
      chan_q <= en_i ? (local_ch & gate_i) : '0;
    end
  end

  assign trig_out_o = trig_q;
  assign chan_out_o = chan_q;

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (trig_out_o == '0 && chan_out_o == '0));

  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_i == '0) |=> (chan_out_o == '0));

  assert_empty_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_map_i == '0) |=> (trig_out_o == '0));

  assert_no_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in_i == '0) |=> (chan_out_o == '0));
endmodule

// File: rtl/xtrig_hub.sv
module xtrig_hub #(
  parameter int unsigned N_TRIG = 8,
  parameter int unsigned N_CHAN = 4,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [N_TRIG-1:0] trig_out,
  input  logic [N_CHAN-1:0] chan_in,
  output logic [N_CHAN-1:0] chan_out,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata
);
  logic                          en;
  logic [N_TRIG-1:0][N_CHAN-1:0] in_map;
  logic [N_TRIG-1:0][N_CHAN-1:0] out_map;
  logic [N_CHAN-1:0]             gate;

  xtrig_regs #(.N_TRIG(N_TRIG), .N_CHAN(N_CHAN), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_o(en),
    .in_map_o(in_map), .out_map_o(out_map), .gate_o(gate)
  );

  xtrig_route #(.N_TRIG(N_TRIG), .N_CHAN(N_CHAN)) u_route (
    .clk(clk), .rst_n(rst_n), .en_i(en), .trig_in_i(trig_in),
    .chan_in_i(chan_in), .in_map_i(in_map), .out_map_i(out_map),
    .gate_i(gate), .trig_out_o(trig_out), .chan_out_o(chan_out)
  );
endmodule

// File: tb/test_xtrig_hub.sv
module test_xtrig_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in = '0;
  logic [7:0]  trig_out;
  logic [3:0]  chan_in = '0;
  logic [3:0]  chan_out;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] t;
    logic [3:0] c;
    string      req;
  } exp_t;
  exp_t sb[$];

  // mirror of the configuration, kept from the requirements
  bit       m_lock = 1'b1;
  bit       m_en = 1'b0;
  bit [3:0] m_in [8];
  bit [3:0] m_out [8];
  bit [3:0] m_gate = '0;

  xtrig_hub i_xtrig_hub (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_out(trig_out),
    .chan_in(chan_in), .chan_out(chan_out), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares outputs in the cycle each item is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check({e.req, " trig_out"}, {24'h0, trig_out}, {24'h0, e.t});
      check({e.req, " chan_out"}, {28'h0, chan_out}, {28'h0, e.c});
    end
  end

  function automatic void model(input logic [7:0] t, input logic [3:0] c,
                                output logic [7:0] et, output logic [3:0] ec);
    logic [3:0] loc;
    loc = '0;
    for (int n = 0; n < 8; n++) if (t[n]) loc = loc | m_in[n];
    et = '0;
    for (int n = 0; n < 8; n++) et[n] = m_en && ((m_out[n] & (loc | c)) != 0);
    ec = m_en ? (loc & m_gate) : 4'h0;
  endfunction

  task automatic step(input logic [7:0] t, input logic [3:0] c, input string req);
    exp_t e;
    @(negedge clk);
    trig_in = t;
    chan_in = c;
    model(t, c, e.t, e.c);
    e.due = cyc + 1;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 12'hFB0) m_lock = (d != 32'hC5AC_CE55);
    else if (!m_lock) begin
      if (a == 12'h000) m_en = d[0];
      if (a == 12'h140) m_gate = d[3:0];
      for (int n = 0; n < 8; n++) begin
        if (a == 12'h020 + 12'(4*n)) m_in[n] = d[3:0];
        if (a == 12'h0A0 + 12'(4*n)) m_out[n] = d[3:0];
      end
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) begin m_in[n] = '0; m_out[n] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 trig_out at reset", {24'h0, trig_out}, 0);
    check("R1 chan_out at reset", {28'h0, chan_out}, 0);
    rd(12'hFB4, 32'h2, "R1 R2 locked after reset");
    rd(12'h000, 32'h0, "R1 control zero");
    rd(12'h0A0, 32'h0, "R1 output mask zero");
    rd(12'h140, 32'h0, "R1 gate zero");

    // R2 writes ignored while locked
    wr(12'h000, 32'h1);
    wr(12'h020, 32'hF);
    rd(12'h000, 32'h0, "R2 control unchanged while locked");
    rd(12'h020, 32'h0, "R2 input mask unchanged while locked");

    // R3 unlock
    wr(12'hFB0, 32'hC5AC_CE55);
    rd(12'hFB4, 32'h0, "R3 unlocked status");

    // configuration: in0 pulse and in5 level share ch0, in3 fans to ch1+ch2
    wr(12'h020, 32'h1);
    wr(12'h034, 32'h1);
    wr(12'h02C, 32'h6);
    wr(12'h038, 32'h8);
    wr(12'h0A0, 32'h1);
    wr(12'h0A8, 32'hF);
    wr(12'h0B0, 32'h4);
    wr(12'h0BC, 32'hA);
    wr(12'h140, 32'h5);
    wr(12'h000, 32'h1);
    rd(12'h02C, 32'h6, "R11 input mask readback");
    rd(12'h0BC, 32'hA, "R11 output mask readback");
    rd(12'h000, 32'h1, "R11 control readback");

    // R5 R9 R10 pulse on in0, then level on in5
    step(8'h01, 4'h0, "R10 pulse in0");
    step(8'h00, 4'h0, "R10 pulse ends");
    step(8'h20, 4'h0, "R10 level in5");
    step(8'h20, 4'h0, "R10 level held");
    step(8'h21, 4'h0, "R9 pulse over level");
    step(8'h20, 4'h0, "R10 level held");
    step(8'h00, 4'h0, "R10 level released");
    // R5 R6 R8 fan-out onto two channels
    step(8'h08, 4'h0, "R5 in3 to ch1 ch2");
    step(8'h48, 4'h0, "R9 in3 and in6");
    // R7 inbound channels
    step(8'h00, 4'h8, "R7 inbound ch3");
    step(8'h00, 4'h1, "R7 inbound ch0");
    step(8'h08, 4'h8, "R7 R9 inbound with local");
    // R6 unmapped input
    step(8'h02, 4'h0, "R6 unmapped input");
    step(8'h00, 4'h0, "R10 idle");
    drain();

    // R4 disable
    wr(12'h000, 32'h0);
    step(8'hFF, 4'hF, "R4 disabled outputs low");
    step(8'h00, 4'h0, "R4 disabled idle");
    drain();
    rd(12'h02C, 32'h6, "R4 mask kept while disabled");
    rd(12'h140, 32'h5, "R4 gate kept while disabled");

    // R3 relock with a wrong value
    wr(12'hFB0, 32'h1234_5678);
    rd(12'hFB4, 32'h2, "R3 relocked status");
    wr(12'h140, 32'hF);
    wr(12'h000, 32'h1);
    rd(12'h140, 32'h5, "R2 gate unchanged while relocked");
    step(8'h01, 4'h0, "R2 enable write ignored");
    step(8'h00, 4'h0, "R2 idle");
    drain();

    // R11 stored width and unmapped offsets
    wr(12'hFB0, 32'hC5AC_CE55);
    wr(12'h020, 32'hFFFF_FFF3);
    rd(12'h020, 32'h3, "R11 only low bits stored");
    rd(12'h144, 32'h0, "R11 unmapped read zero");
    rd(12'h01C, 32'h0, "R11 unmapped read zero below masks");
    rd(12'hFB0, 32'h0, "R11 key register reads zero");

    // R8 gate fully open
    wr(12'h140, 32'hF);
    wr(12'h000, 32'h1);
    step(8'h09, 4'h0, "R8 gate open");
    step(8'h00, 4'h0, "R8 idle");
    drain();

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule